// File: doc/BRIEF.md
# Programmable-Trigger Interrupt Controller

This block collects interrupt requests from a set of on-chip sources and from four external pins, and combines them into one request line toward the processor. Each on-chip source is fixed at build time as either a level source or an edge source. A level source shows its live input in the status register. An edge source latches a pending flag on a rising input, and software clears that flag by writing a one to its status bit. Each external pin passes through a two-flop synchroniser. The pin's field in the trigger-mode register then selects how the pin is interpreted.

Software reaches the block through a small register port: an enable register, a status register, and the trigger-mode register. Reads are combinational. Writes take effect at the next clock edge. The interrupt output is high whenever a source that is enabled shows a set status bit. To mask a source, software clears its enable bit with a read-modify-write. To change one pin's trigger mode, software rewrites only that pin's three-bit field.

Top module: `irq_trigger_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the enable register, the trigger-mode register and every pending flag, and holds `irq_o` low.
- R2: Register map. Address 0 is the enable register: bit i belongs to source i, and it reads back as written. Address 1 is the status register. Address 2 is the trigger-mode register: pin p uses bits [3p+2:3p], and it reads back zero-extended. Address 3 reads zero.
- R3: An on-chip edge source (a `LEVEL_MAP` bit of 0) sets its pending flag when its input is high and was low at the previous clock edge. The flag is visible in the status register right after that edge, and it stays set after the input drops.
- R4: Writing the status register clears each edge pending flag whose data bit is 1. A data bit of 0 leaves that flag unchanged.
- R5: When a new edge and a clearing write reach the same pending flag at the same clock edge, the flag stays set.
- R6: An on-chip level source (a `LEVEL_MAP` bit of 1) shows its live input in the status register. A write to the status register does not change it.
- R7: `irq_o` is the OR over all sources of (status AND enable). The status register reads the raw state whatever the enable register holds.
- R8: External pin p drives status bit `N_INT`+p. Mode code 1 (level high) shows the synchronised pin level and code 0 (level low) shows its inverse. A change at the pin is visible after the second clock edge. Writes to the status register do not affect these bits.
- R9: Mode codes 2 (rising), 3 (falling) and 4 (both edges) latch a pending flag for pin p. A pin change is visible in the status register after the third clock edge. The flag is cleared by writing one to it.
- R10: Mode codes 5, 6 and 7 disable the pin. Its status bit reads 0, and any pending flag it held is dropped, so it does not return when an edge mode is selected again.
- R11: Each pin's mode field acts alone. Rewriting the trigger-mode register with one field changed alters only that pin's behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 enable, 1 status, 2 trigger mode) |
| reg_wdata | input | N_INT+N_EXT | Write data |
| reg_rdata | output | N_INT+N_EXT | Combinational read data for `reg_addr` |
| int_src | input | N_INT | On-chip interrupt sources, synchronous to `clk` |
| ext_pin | input | N_EXT | External interrupt pins, asynchronous |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with the default values: sixteen on-chip sources, four pins, and a level map that marks sources 0 to 5 as level sources. These values give a twenty-bit data path in which the twelve-bit trigger-mode register has to be zero-extended on read. Both kinds of on-chip source are present together. All four pins can be placed in different modes at once, so a test can show that rewriting one field leaves the other pins unchanged.

// File: rtl/irq_trig_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the trigger-programmable interrupt controller.
// Holds the register addresses and the per-pin trigger-mode encoding.
package irq_trig_pkg;

    localparam int TRIG_W = 3;

    localparam logic [1:0] ADDR_ENABLE = 2'd0;
    localparam logic [1:0] ADDR_STATUS = 2'd1;
    localparam logic [1:0] ADDR_TRIG   = 2'd2;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_LVL_LO = 3'd0,
        TRIG_LVL_HI = 3'd1,
        TRIG_RISE   = 3'd2,
        TRIG_FALL   = 3'd3,
        TRIG_BOTH   = 3'd4
    } trig_mode_e;

endpackage

// File: rtl/irq_int_src.sv
`timescale 1ns/1ps
// Module: irq_int_src
// One on-chip interrupt source. With IS_LEVEL set, the live input goes straight
// to status. Otherwise a rising input sets a pending flag that is cleared by a
// one on clr; a new edge takes priority over clr.
// Assumes: src is synchronous to clk.
module irq_int_src #(
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic clr,
    output logic status
);

    logic prev_q;
    logic pend_q;
    logic edge_ev;

    // Purpose: keep last cycle's input for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src;
    end

    // Purpose: form the rising-edge event.
    always_comb begin
        edge_ev = src & ~prev_q;
    end

    // Purpose: pending flag; an edge beats a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (IS_LEVEL) pend_q <= 1'b0;
        else               pend_q <= (pend_q & ~clr) | edge_ev;
    end

    generate
        if (IS_LEVEL) begin : g_level
            // Purpose: level source shows live state.
            always_comb status = src;
        end else begin : g_edge
            // Purpose: edge source shows the latched flag.
            always_comb status = pend_q;
        end
    endgenerate

endmodule

// File: rtl/irq_ext_pin.sv
`timescale 1ns/1ps
// Module: irq_ext_pin
// One external interrupt pin. It synchronises the pin through two flops and
// interprets it according to the 3-bit trigger mode: either a level view or a
// latched edge flag. Codes 5 to 7 disable the pin and drop its flag.
// Assumes: pin is asynchronous; mode and clr are synchronous to clk.
module irq_ext_pin
    import irq_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin,
    input  logic [TRIG_W-1:0] mode,
    input  logic              clr,
    output logic              status
);

    logic sync1_q, sync2_q, hist_q;
    logic pend_q;
    logic rise, fall, edge_ev, is_edge_mode;

    // Purpose: two-flop synchroniser plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            hist_q  <= 1'b0;
        end else begin
            sync1_q <= pin;
            sync2_q <= sync1_q;
            hist_q  <= sync2_q;
        end
    end

    // Purpose: pick the edge event that the selected mode cares about.
    always_comb begin
        rise = sync2_q & ~hist_q;
        fall = ~sync2_q & hist_q;
        edge_ev = 1'b0;
        is_edge_mode = 1'b0;
        case (mode)
            TRIG_RISE: begin edge_ev = rise;        is_edge_mode = 1'b1; end
            TRIG_FALL: begin edge_ev = fall;        is_edge_mode = 1'b1; end
            TRIG_BOTH: begin edge_ev = rise | fall; is_edge_mode = 1'b1; end
            default:   begin edge_ev = 1'b0;        is_edge_mode = 1'b0; end
        endcase
    end

    // Purpose: pending flag, held only while an edge mode is selected.
    always_ff @(posedge clk) begin
        if (!rst_n)             pend_q <= 1'b0;
        else if (!is_edge_mode) pend_q <= 1'b0;
        else                    pend_q <= (pend_q & ~clr) | edge_ev;
    end

    // Purpose: status view for the selected mode.
    always_comb begin
        case (mode)
            TRIG_LVL_LO: status = ~sync2_q;
            TRIG_LVL_HI: status = sync2_q;
            TRIG_RISE,
            TRIG_FALL,
            TRIG_BOTH:   status = pend_q;
            default:     status = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_trigger_ctrl.sv
`timescale 1ns/1ps
// Module: irq_trigger_ctrl (top)
// Interrupt controller with an enable register, a status register (write one
// to clear edge flags) and a trigger-mode register with one field per external
// pin. The combined request is the OR of status AND enable.
// Assumes: N_INT + N_EXT >= 3 * N_EXT, so the data path is wide enough for the
// trigger-mode register; int_src is synchronous to clk.
module irq_trigger_ctrl
    import irq_trig_pkg::*;
#(
    parameter int               N_INT     = 16,
    parameter int               N_EXT     = 4,
    parameter logic [N_INT-1:0] LEVEL_MAP = 16'h003F
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [1:0]             reg_addr,
    input  logic [N_INT+N_EXT-1:0] reg_wdata,
    output logic [N_INT+N_EXT-1:0] reg_rdata,
    input  logic [N_INT-1:0]       int_src,
    input  logic [N_EXT-1:0]       ext_pin,
    output logic                   irq_o
);

    localparam int N_SRC    = N_INT + N_EXT;
    localparam int TRIG_TOT = TRIG_W * N_EXT;

    logic [N_SRC-1:0]    en_q;
    logic [TRIG_TOT-1:0] mode_q;
    logic [N_SRC-1:0]    status;
    logic [N_SRC-1:0]    clr;

    // Purpose: enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  en_q <= '0;
        else if (reg_wr && reg_addr == ADDR_ENABLE)  en_q <= reg_wdata;
    end

    // Purpose: trigger-mode register, one field per external pin.
    always_ff @(posedge clk) begin
        if (!rst_n)                                mode_q <= '0;
        else if (reg_wr && reg_addr == ADDR_TRIG)  mode_q <= reg_wdata[TRIG_TOT-1:0];
    end

    // Purpose: write-one-to-clear mask for the status register.
    always_comb begin
        clr = (reg_wr && reg_addr == ADDR_STATUS) ? reg_wdata : '0;
    end

    generate
        for (genvar i = 0; i < N_INT; i++) begin : g_int
            irq_int_src #(.IS_LEVEL(LEVEL_MAP[i])) u_src (
                .clk    (clk),
                .rst_n  (rst_n),
                .src    (int_src[i]),
                .clr    (clr[i]),
                .status (status[i])
            );
        end
        for (genvar p = 0; p < N_EXT; p++) begin : g_ext
            irq_ext_pin u_pin (
                .clk    (clk),
                .rst_n  (rst_n),
                .pin    (ext_pin[p]),
                .mode   (mode_q[p*TRIG_W +: TRIG_W]),
                .clr    (clr[N_INT+p]),
                .status (status[N_INT+p])
            );
        end
    endgenerate

    // Purpose: combined interrupt request.
    always_comb begin
        irq_o = |(status & en_q);
    end

    // Purpose: combinational register read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_ENABLE: reg_rdata = en_q;
            ADDR_STATUS: reg_rdata = status;
            ADDR_TRIG:   reg_rdata[TRIG_TOT-1:0] = mode_q;
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_trigger_ctrl_chk.sv
`timescale 1ns/1ps
// Module: irq_trigger_ctrl_chk
// Property checker bound to irq_trigger_ctrl. It watches the registers, the
// status vector and the on-chip sources. It keeps its own history flop for the
// on-chip inputs, so edge events are derived independently of the design.
module irq_trigger_ctrl_chk #(
    parameter int               N_INT     = 16,
    parameter int               N_EXT     = 4,
    parameter logic [N_INT-1:0] LEVEL_MAP = 16'h003F
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_wr,
    input logic [1:0]             reg_addr,
    input logic [N_INT+N_EXT-1:0] reg_wdata,
    input logic [N_INT-1:0]       int_src,
    input logic [N_INT+N_EXT-1:0] en_q,
    input logic [3*N_EXT-1:0]     mode_q,
    input logic [N_INT+N_EXT-1:0] status,
    input logic                   irq_o
);

    localparam logic [N_INT-1:0] EDGE_MASK = ~LEVEL_MAP;

    logic [N_INT-1:0] src_d;
    logic [N_INT-1:0] ev_chk;
    logic [N_INT-1:0] edge_stat;
    logic             st_wr;

    // Purpose: checker's own copy of last cycle's on-chip inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) src_d <= '0;
        else        src_d <= int_src;
    end

    // Purpose: derived edge events, edge-source status and status-write flag.
    always_comb begin
        ev_chk    = int_src & ~src_d & EDGE_MASK;
        edge_stat = status[N_INT-1:0] & EDGE_MASK;
        st_wr     = reg_wr && (reg_addr == 2'd1);
    end

    // R1: registers are clear and the request is low right after reset.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (en_q == '0 && mode_q == '0 && !irq_o));

    // R4: a one in the write data clears the flag unless a new edge arrives.
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> ((edge_stat & $past(reg_wdata[N_INT-1:0]) & ~$past(ev_chk)) == '0));

    // R4: a zero in the write data keeps a set flag.
    a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> (($past(edge_stat & ~reg_wdata[N_INT-1:0]) & ~edge_stat) == '0));

    // R5: every edge event sets its flag, even against a clearing write.
    a_r5_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_chk) |=> (($past(ev_chk) & ~edge_stat) == '0));

    // R7: nothing enabled means no request.
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_o);

    generate
        for (genvar p = 0; p < N_EXT; p++) begin : g_dis
            // R10: a disabled pin shows no status.
            a_r10_pin_disabled: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_q[3*p +: 3] > 3'd4) |-> !status[N_INT+p]);
        end
    endgenerate

endmodule

bind irq_trigger_ctrl irq_trigger_ctrl_chk #(
    .N_INT     (N_INT),
    .N_EXT     (N_EXT),
    .LEVEL_MAP (LEVEL_MAP)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .int_src   (int_src),
    .en_q      (en_q),
    .mode_q    (mode_q),
    .status    (status),
    .irq_o     (irq_o)
);

// File: tb/test_irq_trigger_ctrl.sv
`timescale 1ns/1ps
// Bench for irq_trigger_ctrl. A behavioural reference model updates on every
// rising clock edge. Both outputs are compared with it at every falling edge,
// and directed checks with fixed expected values follow the requirements.
module test_irq_trigger_ctrl;

    localparam int          N_INT = 16;
    localparam int          N_EXT = 4;
    localparam int          N_SRC = N_INT + N_EXT;
    localparam logic [15:0] LMAP  = 16'h003F;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [N_SRC-1:0] reg_wdata = '0;
    logic [N_SRC-1:0] reg_rdata;
    logic [N_INT-1:0] int_src = '0;
    logic [N_EXT-1:0] ext_pin = '0;
    logic             irq_o;

    int total = 0;
    int bad = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_trigger_ctrl #(.N_INT(N_INT), .N_EXT(N_EXT), .LEVEL_MAP(LMAP)) i_irq_trigger_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_src(int_src),
        .ext_pin(ext_pin), .irq_o(irq_o)
    );

    // ---------------- reference model ----------------
    logic [N_SRC-1:0] m_en = '0;
    logic [11:0]      m_mode = '0;
    logic [N_SRC-1:0] m_pend = '0;
    logic [N_INT-1:0] m_prev = '0;
    logic [N_EXT-1:0] m_s1 = '0, m_s2 = '0, m_s3 = '0;

    function automatic logic [N_SRC-1:0] m_status();
        logic [N_SRC-1:0] s;
        s = '0;
        for (int i = 0; i < N_INT; i++)
            s[i] = LMAP[i] ? int_src[i] : m_pend[i];
        for (int p = 0; p < N_EXT; p++) begin
            int md;
            md = int'(m_mode[3*p +: 3]);
            if (md == 0)      s[N_INT+p] = ~m_s2[p];
            else if (md == 1) s[N_INT+p] = m_s2[p];
            else if (md <= 4) s[N_INT+p] = m_pend[N_INT+p];
            else              s[N_INT+p] = 1'b0;
        end
        return s;
    endfunction

    function automatic logic [N_SRC-1:0] m_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return m_en;
            2'd1:    return m_status();
            2'd2:    return {8'h00, m_mode};
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [N_SRC-1:0] c;
        if (!rst_n) begin
            m_en = '0; m_mode = '0; m_pend = '0; m_prev = '0;
            m_s1 = '0; m_s2 = '0; m_s3 = '0;
        end else begin
            c = (reg_wr && reg_addr == 2'd1) ? reg_wdata : '0;
            for (int i = 0; i < N_INT; i++)
                m_pend[i] = LMAP[i] ? 1'b0 : ((m_pend[i] & ~c[i]) | (int_src[i] & ~m_prev[i]));
            m_prev = int_src;
            for (int p = 0; p < N_EXT; p++) begin
                int md;
                logic ev;
                md = int'(m_mode[3*p +: 3]);
                ev = (md == 2) ? (m_s2[p] & ~m_s3[p]) :
                     (md == 3) ? (~m_s2[p] & m_s3[p]) :
                     (md == 4) ? (m_s2[p] ^ m_s3[p]) : 1'b0;
                if (md >= 2 && md <= 4)
                    m_pend[N_INT+p] = (m_pend[N_INT+p] & ~c[N_INT+p]) | ev;
                else
                    m_pend[N_INT+p] = 1'b0;
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
            if (reg_wr && reg_addr == 2'd0) m_en = reg_wdata;
            if (reg_wr && reg_addr == 2'd2) m_mode = reg_wdata[11:0];
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("R7 model irq_o", {31'd0, irq_o}, {31'd0, |(m_status() & m_en)});
            check("R2 model reg_rdata", {12'd0, reg_rdata}, {12'd0, m_rdata(reg_addr)});
        end
    end

    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic cycn(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [N_SRC-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        cyc();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = {12'd0, reg_rdata};
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        cycn(3);
        rst_n = 1'b1;
        cyc();
        cmp_on = 1'b1;

        // R1: reset state
        rd(2'd0, v); check("R1 enable after reset", v, 32'h0);
        rd(2'd2, v); check("R1 mode after reset", v, 32'h0);
        check("R1 irq_o after reset", {31'd0, irq_o}, 32'h0);
        // R8: level-low pins at reset read 1 while low
        rd(2'd1, v); check("R8 level-low default status", v, 32'hF0000);

        // R2 / R10: disable all pins, read back
        wr_reg(2'd2, 20'h00FFF);
        rd(2'd2, v); check("R2 mode readback", v, 32'hFFF);
        rd(2'd1, v); check("R10 disabled pins status", v, 32'h0);
        wr_reg(2'd0, 20'hABCDE);
        rd(2'd0, v); check("R2 enable readback", v, 32'hABCDE);
        rd(2'd3, v); check("R2 address 3 reads zero", v, 32'h0);
        wr_reg(2'd0, 20'h0);

        // R3: edge source 8
        int_src[8] = 1'b1; cyc();
        rd(2'd1, v); check("R3 edge latched", v, 32'h100);
        int_src[8] = 1'b0; cyc();
        rd(2'd1, v); check("R3 edge held after drop", v, 32'h100);

        // R7: raw status with enable clear, then enable
        check("R7 masked no irq", {31'd0, irq_o}, 32'h0);
        wr_reg(2'd0, 20'h00100);
        check("R7 enabled irq", {31'd0, irq_o}, 32'h1);

        // R4: zero write keeps, one write clears
        wr_reg(2'd1, 20'h0);
        rd(2'd1, v); check("R4 zero write keeps", v, 32'h100);
        wr_reg(2'd1, 20'h00100);
        rd(2'd1, v); check("R4 one write clears", v, 32'h0);
        check("R4 irq drops after clear", {31'd0, irq_o}, 32'h0);

        // R5: edge and clear together
        int_src[8] = 1'b1;
        wr_reg(2'd1, 20'h00100);
        rd(2'd1, v); check("R5 edge beats clear", v, 32'h100);
        int_src[8] = 1'b0;
        wr_reg(2'd1, 20'h00100);
        rd(2'd1, v); check("R5 cleared afterwards", v, 32'h0);

        // R6: level source 2
        int_src[2] = 1'b1; #1;
        rd(2'd1, v); check("R6 level follows", v, 32'h4);
        wr_reg(2'd1, 20'h00004);
        rd(2'd1, v); check("R6 level ignores clear", v, 32'h4);
        int_src[2] = 1'b0; #1;
        rd(2'd1, v); check("R6 level drops", v, 32'h0);
        wr_reg(2'd0, 20'h0);

        // R8: pin0 level high, latency two edges
        wr_reg(2'd2, 20'h00FF9);
        ext_pin[0] = 1'b1; cyc();
        rd(2'd1, v); check("R8 level high after one edge", v, 32'h0);
        cyc();
        rd(2'd1, v); check("R8 level high after two edges", v, 32'h10000);
        wr_reg(2'd1, 20'h10000);
        rd(2'd1, v); check("R8 level ignores clear", v, 32'h10000);
        // R11: pin1 to level low; pin0 unchanged
        wr_reg(2'd2, 20'h00FC1);
        rd(2'd1, v); check("R11 pin1 level low, pin0 kept", v, 32'h30000);

        // R9: pin2 rising
        wr_reg(2'd2, 20'h00E81);
        ext_pin[2] = 1'b1; cycn(2);
        rd(2'd1, v); check("R9 rise not yet", v, 32'h30000);
        cyc();
        rd(2'd1, v); check("R9 rise latched third edge", v, 32'h70000);
        ext_pin[2] = 1'b0; cycn(4);
        rd(2'd1, v); check("R9 rising ignores fall", v, 32'h70000);
        wr_reg(2'd1, 20'h40000);
        rd(2'd1, v); check("R9 rise cleared", v, 32'h30000);

        // R9: pin3 falling
        ext_pin[3] = 1'b1; cycn(4);
        wr_reg(2'd2, 20'h00681);
        ext_pin[3] = 1'b0; cycn(3);
        rd(2'd1, v); check("R9 fall latched", v, 32'hB0000);
        wr_reg(2'd1, 20'h80000);

        // R9: pin1 both edges
        wr_reg(2'd2, 20'h006A1);
        ext_pin[1] = 1'b1; cycn(3);
        rd(2'd1, v); check("R9 both rise", v, 32'h30000);
        wr_reg(2'd1, 20'h20000);
        rd(2'd1, v); check("R9 both cleared", v, 32'h10000);
        ext_pin[1] = 1'b0; cycn(3);
        rd(2'd1, v); check("R9 both fall", v, 32'h30000);

        // R10: disable drops pending, re-enable stays clear
        wr_reg(2'd2, 20'h006A9);
        rd(2'd1, v); check("R10 disabled hides", v, 32'h10000);
        wr_reg(2'd2, 20'h006A1);
        rd(2'd1, v); check("R10 pending dropped", v, 32'h10000);
        wr_reg(2'd2, 20'h006B1);
        ext_pin[1] = 1'b1; cycn(4);
        rd(2'd1, v); check("R10 mode 6 ignores edge", v, 32'h10000);

        // R7: external level enable and mask
        wr_reg(2'd0, 20'h10000);
        check("R7 pin irq", {31'd0, irq_o}, 32'h1);
        wr_reg(2'd0, 20'h0);
        check("R7 pin masked", {31'd0, irq_o}, 32'h0);
        rd(2'd1, v); check("R7 raw status while masked", v, 32'h10000);

        // R1: reset again mid-run
        wr_reg(2'd0, 20'hFFFFF);
        rst_n = 1'b0; cyc(); rst_n = 1'b1;
        check("R1 irq low after reset", {31'd0, irq_o}, 32'h0);
        rd(2'd0, v); check("R1 enable cleared", v, 32'h0);

        cycn(2);
        finish_run();
    end

endmodule